// File: doc/BRIEF.md
# ARINC 429 Receive Word Validator

This block sits between a three-level window comparator and a receive FIFO. Every sample period it takes one-hot indications of a ONE, ZERO or NULL bus level. It rebuilds 32-bit ARINC 429 words from them and issues a one-cycle load strobe with the finished word. A bit counts as real only when a run of level samples is followed by a run of null samples. Consecutive bits must arrive inside a fixed spacing window. After each word, and after any timing violation, a fresh word gap of null samples is required before reception starts again.

A completed word passes through two optional gates before it leaves the block. The label gate looks the label up in a 256-entry enable table. The decode gate compares two programmed bits against ARINC bits 9 and 10. Both gates must pass. When parity checking is on, bit 32 of the word is replaced by an error flag. The label table is written through a synchronous port that has single-entry writes and whole-table set and clear pulses.

Top module: `a429_rx_validator`

## Requirements
- R1: After reset, `word_valid` is 0, `word_data` is 0, every label table entry is 0, and the block waits for a word gap before it accepts bits.
- R2: In high-speed mode one sample is taken per clock. A bit sent as 5 ONE (or ZERO) samples followed by 5 NULL samples is recognised. The first bit received (ARINC bit n) is stored in `word_data[n-1]`, so the label, ARINC bits 1-8, is `word_data[7:0]`.
- R3: Bits whose start-to-start spacing lies between 8 and 12 samples (4+4 and 6+6 sample bits) are accepted. When no new bit arrives within 12 samples of the previous bit, the whole word is rejected (7+7 sample bits).
- R4: After a word ends or is aborted, reception is armed only after the NULL input has been seen on 3 consecutive checks spaced 10 samples apart. A non-null check restarts this count. A word that starts after too short a gap is not delivered.
- R5: With `lbl_chk_en` = 1, a word is delivered only if the table entry at index `word_data[7:0]` is 1. With it at 0, labels are not checked.
- R6: With `dec_chk_en` = 1, a word is delivered only if ARINC bit 9 equals `dec_match[0]` and ARINC bit 10 equals `dec_match[1]`. These are `word_data[8]` and `word_data[9]`.
- R7: With both gates enabled, a word is delivered only if it passes both. A word that fails any gate gives no strobe at all.
- R8: With `par_chk_en` = 1, `word_data[31]` is 0 when the 32 received bits hold an odd number of ones and 1 when they hold an even number. With it at 0, bit 32 is delivered as received.
- R9: A table write sets one entry to `tbl_wr_bit`. `tbl_set_all` sets every entry to 1 and `tbl_clr_all` sets every entry to 0. If pulses coincide, clear-all takes priority over set-all, and set-all takes priority over a single write.
- R10: In low-speed mode one sample is taken every 8 clocks, so bit spacing and word gap scale by 8. Words held at 8 clocks per sample are recovered just as R2 describes.
- R11: `word_valid` lasts exactly one clock per word. `word_data` keeps the last delivered word until the next strobe.
- R12: A word cut short (the bus goes null before 32 bits) gives no strobe. It leaves nothing behind that merges with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (one sample per clock in high speed) |
| rst_n | input | 1 | Synchronous active-low reset |
| low_speed | input | 1 | 1 = sample every 8 clocks, 0 = every clock |
| lvl_one | input | 1 | Comparator reports ONE level |
| lvl_zero | input | 1 | Comparator reports ZERO level |
| lvl_null | input | 1 | Comparator reports NULL level |
| lbl_chk_en | input | 1 | Enable label table gate |
| dec_chk_en | input | 1 | Enable ARINC bit 9/10 match gate |
| dec_match | input | 2 | [0] expected bit 9, [1] expected bit 10 |
| par_chk_en | input | 1 | Replace bit 32 by parity error flag |
| tbl_wr_en | input | 1 | Write one label table entry |
| tbl_wr_addr | input | 8 | Label table entry index |
| tbl_wr_bit | input | 1 | Value written to the entry |
| tbl_set_all | input | 1 | Set every table entry |
| tbl_clr_all | input | 1 | Clear every table entry |
| word_valid | output | 1 | One-cycle load strobe toward the FIFO |
| word_data | output | 32 | Delivered word |

## Verification
The recovery path is tried with random 32-bit words sent at the nominal 5+5 sample shape. It is also tried at the two edges of the spacing window (4+4 and 6+6) and just outside the window (7+7), so a wrong bound shows as a lost or a wrongly kept word. Truncated words and words with a too-short gap show whether aborted state leaks into later words and whether the gap rule holds. Word lists chosen around table contents, bit 9/10 values and odd or even ones counts separate the label, decode and parity rules. Low-speed runs confirm that all timing scales together.

// File: rtl/a429_rx_pkg.sv
// Package: shared constants and types of the ARINC 429 receive validator.
package a429_rx_pkg;
    localparam int WORD_W  = 32;
    localparam int LABEL_W = 8;

    // Receive sequencer: waiting for a word gap, or taking bits of a word
    typedef enum logic [0:0] {
        RX_GAP  = 1'b0,
        RX_LIVE = 1'b1
    } rx_state_t;
endpackage

// File: rtl/a429_sampler.sv
// Level sampler: produces the sample tick (every clock, or every LS_DIV
// clocks in low speed) and keeps three SR_LEN-deep sample histories for
// ONE, ZERO and NULL. A bit is flagged when the older half of ONE or ZERO
// holds a run of RUN_LEN ones and the newer half of NULL holds the same.
// Assumes the three level inputs are one-hot or all zero.
module a429_sampler #(
    parameter int SR_LEN  = 10,
    parameter int RUN_LEN = 3,
    parameter int LS_DIV  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_speed,
    input  logic in_one,
    input  logic in_zero,
    input  logic in_null,
    input  logic flush,
    output logic tick,
    output logic hit,
    output logic hit_val
);
    localparam int HALF  = SR_LEN / 2;
    localparam int PRE_W = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [SR_LEN-1:0] one_sr, zero_sr, null_sr;
    logic              one_run, zero_run, null_run;

    function automatic logic has_run(input logic [HALF-1:0] f);
        logic r;
        r = 1'b0;
        for (int i = 0; i <= HALF - RUN_LEN; i++) begin
            if (&f[i +: RUN_LEN]) r = 1'b1;
        end
        return r;
    endfunction

    // Prescaler: free-running divider that spaces low-speed samples
    always_ff @(posedge clk) begin
        if (!rst_n)                               pre_cnt <= '0;
        else if (pre_cnt == PRE_W'(LS_DIV - 1))   pre_cnt <= '0;
        else                                      pre_cnt <= pre_cnt + 1'b1;
    end

    assign tick = !low_speed || (pre_cnt == '0);

    // Run detection over the two halves of the histories
    always_comb begin
        one_run  = has_run(one_sr[SR_LEN-1 -: HALF]);
        zero_run = has_run(zero_sr[SR_LEN-1 -: HALF]);
        null_run = has_run(null_sr[HALF-1:0]);
        hit      = tick && !flush && (one_run || zero_run) && null_run;
        hit_val  = one_run;
    end

    // Histories: shift on tick, restart level histories after a bit
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            one_sr  <= '0;
            zero_sr <= '0;
            null_sr <= '0;
        end else if (tick) begin
            null_sr <= {null_sr[SR_LEN-2:0], in_null};
            if (hit) begin
                one_sr  <= {{(SR_LEN-1){1'b0}}, in_one};
                zero_sr <= {{(SR_LEN-1){1'b0}}, in_zero};
            end else begin
                one_sr  <= {one_sr[SR_LEN-2:0], in_one};
                zero_sr <= {zero_sr[SR_LEN-2:0], in_zero};
            end
        end
    end
endmodule

// File: rtl/a429_word_seq.sv
// Word sequencer: counts recognised bits into a 32-bit word, enforces the
// MIN_SP..MAX_SP bit spacing, and runs the word-gap timer that samples
// NULL every GAP_PERIOD ticks and arms after GAP_NULLS hits in a row.
// Any violation drops the partial word and returns to the gap wait.
module a429_word_seq
    import a429_rx_pkg::*;
#(
    parameter int MIN_SP     = 8,
    parameter int MAX_SP     = 12,
    parameter int GAP_PERIOD = 10,
    parameter int GAP_NULLS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hit,
    input  logic              hit_val,
    input  logic              in_null,
    output logic              flush,
    output logic              eos,
    output logic [WORD_W-1:0] eos_word
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int SP_W  = $clog2(MAX_SP + 1);
    localparam int GT_W  = (GAP_PERIOD > 1) ? $clog2(GAP_PERIOD) : 1;
    localparam int GC_W  = $clog2(GAP_NULLS + 1);

    rx_state_t          state;
    logic [BIT_W-1:0]   bit_cnt;
    logic [SP_W-1:0]    sp_cnt;
    logic [GT_W-1:0]    gap_tmr;
    logic [GC_W-1:0]    gap_cnt;
    logic [WORD_W-1:0]  shreg;
    logic               sp_bad;

    assign flush  = (state == RX_GAP);
    assign sp_bad = (bit_cnt != '0) &&
                    ((sp_cnt < SP_W'(MIN_SP)) || (sp_cnt > SP_W'(MAX_SP)));

    // Sequencer: gap arming, bit accounting and end-of-sequence capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_GAP;
            bit_cnt  <= '0;
            sp_cnt   <= '0;
            gap_tmr  <= '0;
            gap_cnt  <= '0;
            shreg    <= '0;
            eos      <= 1'b0;
            eos_word <= '0;
        end else begin
            eos <= 1'b0;
            if (tick) begin
                case (state)
                    RX_GAP: begin
                        if (gap_tmr == GT_W'(GAP_PERIOD - 1)) begin
                            gap_tmr <= '0;
                            if (!in_null) begin
                                gap_cnt <= '0;
                            end else if (gap_cnt == GC_W'(GAP_NULLS - 1)) begin
                                gap_cnt <= '0;
                                bit_cnt <= '0;
                                sp_cnt  <= '0;
                                state   <= RX_LIVE;
                            end else begin
                                gap_cnt <= gap_cnt + 1'b1;
                            end
                        end else begin
                            gap_tmr <= gap_tmr + 1'b1;
                        end
                    end
                    RX_LIVE: begin
                        if (hit && sp_bad) begin
                            state   <= RX_GAP;
                            gap_tmr <= '0;
                            gap_cnt <= '0;
                            bit_cnt <= '0;
                        end else if (hit) begin
                            shreg[bit_cnt] <= hit_val;
                            sp_cnt         <= SP_W'(1);
                            if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                                eos      <= 1'b1;
                                eos_word <= {hit_val, shreg[WORD_W-2:0]};
                                state    <= RX_GAP;
                                gap_tmr  <= '0;
                                gap_cnt  <= '0;
                                bit_cnt  <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else if (bit_cnt != '0) begin
                            if (sp_cnt >= SP_W'(MAX_SP)) begin
                                state   <= RX_GAP;
                                gap_tmr <= '0;
                                gap_cnt <= '0;
                                bit_cnt <= '0;
                            end else begin
                                sp_cnt <= sp_cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= RX_GAP;
                endcase
            end
        end
    end
endmodule

// File: rtl/a429_label_table.sv
// Label enable table: 2**LABEL_W one-bit entries with a synchronous write
// port (single entry, set-all, clear-all; clear-all wins, then set-all)
// and an asynchronous read of one entry.
module a429_label_table #(
    parameter int LABEL_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LABEL_W-1:0]      wr_addr,
    input  logic                    wr_bit,
    input  logic                    set_all,
    input  logic                    clr_all,
    input  logic [LABEL_W-1:0]      rd_addr,
    output logic                    rd_bit,
    output logic [(1<<LABEL_W)-1:0] tbl_vec
);
    // Table storage: prioritised bulk and single writes
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) tbl_vec <= '0;
        else if (set_all)      tbl_vec <= '1;
        else if (wr_en)        tbl_vec[wr_addr] <= wr_bit;
    end

    assign rd_bit = tbl_vec[rd_addr];
endmodule

// File: rtl/a429_word_filter.sv
// Word gate: accepts a completed word when the label and decode gates
// pass, substitutes the parity error flag in the top bit when enabled, and
// registers the one-cycle load strobe plus the held output word.
module a429_word_filter
    import a429_rx_pkg::*;
#(
    parameter int DEC_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eos,
    input  logic [WORD_W-1:0] eos_word,
    input  logic              lbl_hit,
    input  logic              lbl_chk_en,
    input  logic              dec_chk_en,
    input  logic [1:0]        dec_match,
    input  logic              par_chk_en,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    logic              pass;
    logic [WORD_W-1:0] out_word;

    // Gate decision and parity substitution
    always_comb begin
        pass = (!lbl_chk_en || lbl_hit) &&
               (!dec_chk_en || (eos_word[DEC_LSB +: 2] == dec_match));
        out_word = eos_word;
        if (par_chk_en) out_word[WORD_W-1] = ~(^eos_word);
    end

    // Output register: strobe for one clock, hold data between words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= eos && pass;
            if (eos && pass) word_data <= out_word;
        end
    end
endmodule

// File: rtl/a429_rx_validator.sv
// Top: ARINC 429 receive word validator. Joins the sampler, the word
// sequencer, the label table and the word gate. Assumes control inputs are
// changed only while the bus is idle.
module a429_rx_validator
    import a429_rx_pkg::*;
#(
    parameter int SR_LEN     = 10,
    parameter int RUN_LEN    = 3,
    parameter int LS_DIV     = 8,
    parameter int MIN_SP     = 8,
    parameter int MAX_SP     = 12,
    parameter int GAP_PERIOD = 10,
    parameter int GAP_NULLS  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               low_speed,
    input  logic               lvl_one,
    input  logic               lvl_zero,
    input  logic               lvl_null,
    input  logic               lbl_chk_en,
    input  logic               dec_chk_en,
    input  logic [1:0]         dec_match,
    input  logic               par_chk_en,
    input  logic               tbl_wr_en,
    input  logic [LABEL_W-1:0] tbl_wr_addr,
    input  logic               tbl_wr_bit,
    input  logic               tbl_set_all,
    input  logic               tbl_clr_all,
    output logic               word_valid,
    output logic [WORD_W-1:0]  word_data
);
    logic                    tick, hit, hit_val, flush, eos, lbl_hit;
    logic [WORD_W-1:0]       eos_word;
    logic [(1<<LABEL_W)-1:0] tbl_vec;

    a429_sampler #(.SR_LEN(SR_LEN), .RUN_LEN(RUN_LEN), .LS_DIV(LS_DIV)) u_samp (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
        .in_one(lvl_one), .in_zero(lvl_zero), .in_null(lvl_null),
        .flush(flush), .tick(tick), .hit(hit), .hit_val(hit_val)
    );

    a429_word_seq #(.MIN_SP(MIN_SP), .MAX_SP(MAX_SP),
                    .GAP_PERIOD(GAP_PERIOD), .GAP_NULLS(GAP_NULLS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .hit_val(hit_val),
        .in_null(lvl_null), .flush(flush), .eos(eos), .eos_word(eos_word)
    );

    a429_label_table #(.LABEL_W(LABEL_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
        .wr_bit(tbl_wr_bit), .set_all(tbl_set_all), .clr_all(tbl_clr_all),
        .rd_addr(eos_word[LABEL_W-1:0]), .rd_bit(lbl_hit), .tbl_vec(tbl_vec)
    );

    a429_word_filter u_filt (
        .clk(clk), .rst_n(rst_n), .eos(eos), .eos_word(eos_word),
        .lbl_hit(lbl_hit), .lbl_chk_en(lbl_chk_en), .dec_chk_en(dec_chk_en),
        .dec_match(dec_match), .par_chk_en(par_chk_en),
        .word_valid(word_valid), .word_data(word_data)
    );
endmodule

// File: rtl/a429_rx_checker.sv
// Checker: properties on the validator's outputs against its controls and
// its label table contents. Attached to every validator instance by bind.
module a429_rx_checker #(
    parameter int WORD_W   = 32,
    parameter int LABEL_W  = 8,
    parameter int MIN_WORD = 248
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_valid,
    input  logic [WORD_W-1:0]       word_data,
    input  logic                    lbl_chk_en,
    input  logic                    dec_chk_en,
    input  logic [1:0]              dec_match,
    input  logic [(1<<LABEL_W)-1:0] tbl_vec
);
    logic [(1<<LABEL_W)-1:0] vec_q;
    logic                    lbl_q, dec_en_q;
    logic [1:0]              dec_q;
    logic [15:0]             since;

    // Copies of the gate inputs as seen in the cycle the word was judged
    always_ff @(posedge clk) begin
        vec_q    <= tbl_vec;
        lbl_q    <= lbl_chk_en;
        dec_en_q <= dec_chk_en;
        dec_q    <= dec_match;
    end

    // Clocks since reset or since the last strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || word_valid) since <= '0;
        else if (since != 16'hFFFF) since <= since + 1'b1;
    end

    assert_one_cycle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_data));

    assert_label_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && lbl_q) |-> vec_q[word_data[LABEL_W-1:0]]);

    assert_decode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && dec_en_q) |-> (word_data[9:8] == dec_q));

    // R3/R4: a word needs 31 spacings of at least 8 samples plus a gap
    assert_word_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (since >= 16'(MIN_WORD)));
endmodule

bind a429_rx_validator a429_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .lbl_chk_en(lbl_chk_en), .dec_chk_en(dec_chk_en), .dec_match(dec_match),
    .tbl_vec(tbl_vec)
);

// File: tb/test_a429_rx_validator.sv
`timescale 1ns/1ps
module test_a429_rx_validator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_speed = 1'b0;
    logic        lvl_one = 1'b0, lvl_zero = 1'b0, lvl_null = 1'b1;
    logic        lbl_chk_en = 1'b0, dec_chk_en = 1'b0, par_chk_en = 1'b0;
    logic [1:0]  dec_match = 2'b00;
    logic        tbl_wr_en = 1'b0, tbl_wr_bit = 1'b0;
    logic [7:0]  tbl_wr_addr = 8'h00;
    logic        tbl_set_all = 1'b0, tbl_clr_all = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;

    int          tests = 0, fails = 0, hold = 1;
    int unsigned seed_val;
    logic        prev_v = 1'b0;
    logic        tbl_model [256];
    logic [31:0] exp_q[$], got_q[$];
    logic [31:0] last_exp = 32'h0;

    always #2 clk = ~clk;

    a429_rx_validator i_a429_rx_validator (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
        .lvl_one(lvl_one), .lvl_zero(lvl_zero), .lvl_null(lvl_null),
        .lbl_chk_en(lbl_chk_en), .dec_chk_en(dec_chk_en), .dec_match(dec_match),
        .par_chk_en(par_chk_en), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_bit(tbl_wr_bit), .tbl_set_all(tbl_set_all), .tbl_clr_all(tbl_clr_all),
        .word_valid(word_valid), .word_data(word_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Output monitor: collect strobes, flag strobes longer than one clock (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) got_q.push_back(word_data);
            if (word_valid && prev_v) chk(1'b0, "R11 strobe width", 32'd2, 32'd1);
        end
        prev_v = word_valid;
    end

    // Watchdog: a hung run is a failed check and still ends with the summary
    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic put(input logic o, input logic z, input logic n);
        lvl_one = o; lvl_zero = z; lvl_null = n;
        repeat (hold) @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input int hl, input int nl);
        repeat (hl) put(v, ~v, 1'b0);
        repeat (nl) put(1'b0, 1'b0, 1'b1);
    endtask

    task automatic send_word(input logic [31:0] w, input int hl, input int nl,
                             input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i], hl, nl);
    endtask

    task automatic gap(input int n);
        repeat (n) put(1'b0, 1'b0, 1'b1);
    endtask

    // Expected result from the requirements: {delivered, word}
    function automatic logic [32:0] model(input logic [31:0] w);
        logic        ok;
        logic [31:0] o;
        ok = (!lbl_chk_en || tbl_model[w[7:0]]) && (!dec_chk_en || (w[9:8] == dec_match));
        o  = w;
        if (par_chk_en) o[31] = ~(^w);
        return {ok, o};
    endfunction

    task automatic xmit(input logic [31:0] w);
        logic [32:0] m;
        m = model(w);
        send_word(w, 5, 5, 32);
        gap(50);
        if (m[32]) begin
            exp_q.push_back(m[31:0]);
            last_exp = m[31:0];
        end
    endtask

    task automatic check_words(input string req);
        chk(got_q.size() == exp_q.size(), {req, " word count"},
            32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], {req, " word value"}, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic tbl_op(input logic we, input logic [7:0] a, input logic b,
                          input logic sa, input logic ca);
        tbl_wr_en = we; tbl_wr_addr = a; tbl_wr_bit = b;
        tbl_set_all = sa; tbl_clr_all = ca;
        @(negedge clk);
        tbl_wr_en = 1'b0; tbl_set_all = 1'b0; tbl_clr_all = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if (ca) tbl_model[i] = 1'b0;
            else if (sa) tbl_model[i] = 1'b1;
            else if (we && (i == int'(a))) tbl_model[i] = b;
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [1:0] d);
        logic [31:0] w;
        w = $urandom;
        w[7:0] = lbl;
        w[9:8] = d;
        return w;
    endfunction

    initial begin
        seed_val = $urandom(32'hA429);
        for (int i = 0; i < 256; i++) tbl_model[i] = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(word_valid == 1'b0, "R1 valid in reset", 32'(word_valid), 32'd0);
        chk(word_data == 32'h0, "R1 data in reset", word_data, 32'h0);
        rst_n = 1'b1;
        // R1: a word right after reset, with no gap, is not taken
        send_word(32'h1234_5678, 5, 5, 32);
        gap(60);
        check_words("R1 no gap after reset");

        // R2: random words at the nominal shape, no gates
        for (int k = 0; k < 6; k++) xmit($urandom);
        xmit(32'hFFFF_FFFF);
        xmit(32'h0000_0001);
        check_words("R2 nominal words");
        chk(word_data == last_exp, "R11 data held", word_data, last_exp);

        // R3: spacing window edges
        begin
            logic [31:0] w;
            w = $urandom; send_word(w, 4, 4, 32); gap(50); exp_q.push_back(w);
            w = $urandom; send_word(w, 6, 6, 32); gap(50); exp_q.push_back(w);
            check_words("R3 spacing 8 and 12");
            w = $urandom; send_word(w, 7, 7, 32); gap(60);
            xmit($urandom);
            check_words("R3 spacing 14 rejected");
        end

        // R12: truncated word, then a clean one
        send_word($urandom, 5, 5, 20);
        gap(60);
        xmit(32'hC0DE_0042);
        check_words("R12 truncated word");

        // R4: too short a gap drops the following word
        begin
            logic [31:0] wa, wb;
            wa = $urandom; wb = $urandom;
            send_word(wa, 5, 5, 32); gap(10); exp_q.push_back(wa);
            send_word(wb, 5, 5, 32); gap(60);
            xmit($urandom);
            check_words("R4 short gap");
        end

        // R8: parity flag substitution, odd and even ones counts
        par_chk_en = 1'b1;
        xmit(32'h0000_0007);
        xmit(32'h8000_0003);
        xmit(32'h0000_0003);
        for (int k = 0; k < 3; k++) xmit($urandom);
        check_words("R8 parity on");
        par_chk_en = 1'b0;
        xmit(32'h8000_0001);
        check_words("R8 parity off");

        // R9/R5: table writes and the label gate
        tbl_op(1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
        tbl_op(1'b1, 8'hA5, 1'b1, 1'b0, 1'b0);
        lbl_chk_en = 1'b1;
        xmit(mk(8'h3C, 2'b01));
        xmit(mk(8'h5A, 2'b01));
        xmit(mk(8'hA5, 2'b10));
        check_words("R5 label gate");
        tbl_op(1'b1, 8'h5A, 1'b0, 1'b1, 1'b0);
        xmit(mk(8'h5A, 2'b00));
        check_words("R9 set-all beats write");
        tbl_op(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        xmit(mk(8'h3C, 2'b00));
        check_words("R9 clear-all beats set-all");
        tbl_op(1'b1, 8'h77, 1'b1, 1'b0, 1'b0);
        xmit(mk(8'h77, 2'b11));
        xmit(mk(8'h76, 2'b11));
        check_words("R9 single write");
        lbl_chk_en = 1'b0;
        xmit(mk(8'h76, 2'b11));
        check_words("R5 gate off");

        // R6: decode gate
        dec_chk_en = 1'b1;
        dec_match = 2'b10;
        xmit(mk(8'h11, 2'b10));
        xmit(mk(8'h12, 2'b01));
        xmit(mk(8'h13, 2'b11));
        xmit(mk(8'h14, 2'b10));
        check_words("R6 decode gate");

        // R7: both gates
        lbl_chk_en = 1'b1;
        xmit(mk(8'h77, 2'b10));
        xmit(mk(8'h77, 2'b00));
        xmit(mk(8'h12, 2'b10));
        check_words("R7 both gates");
        lbl_chk_en = 1'b0;
        dec_chk_en = 1'b0;

        // R10: low speed, 8 clocks per sample
        low_speed = 1'b1;
        hold = 8;
        gap(20);
        xmit($urandom);
        xmit(32'hA5A5_5A5A);
        check_words("R10 low speed");
        hold = 1;
        low_speed = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule